// File: doc/BRIEF.md
# Version Bank with Content-Addressed Clear

This block is one bank of a multi-version block buffer. It keeps up to four cache blocks in the order they arrived, using a head pointer and a tail pointer. The same entries can also be searched fully associatively on valid bit and address. A block offered for insertion replaces in place any valid entry that has the same address. Otherwise it takes the tail slot. As a result, no address ever sits in more than one valid entry of the bank. The oldest slot can be drained through the head. Single entries can be invalidated or cleaned by address, and neither action moves the pointers.

Each bank also carries a speculative flag and a version number. A re-initialisation command sets both. A commit command clears the flag. Choosing which bank a block belongs to is the job of the logic around the bank.

A single 3-bit command acts on each clock edge. A separate lookup port is purely combinational: it returns hit, dirty, read-version set and data for any address in the same cycle.

Top module: `vbank_top`

## Requirements
- R1: After synchronous reset the bank is empty and not full, the speculative flag is 0, the version is 0, and every lookup misses.
- R2: An insert (cmd=1) of an address that no valid entry holds, while fewer than 4 slots are occupied, reports cmd_ok=1. It writes the block with valid=1 at the tail and advances the tail. From the next cycle the block is visible on the lookup port.
- R3: An insert of an address that a valid entry already holds reports cmd_ok=1. It overwrites that entry's dirty, read-version set and data in place. The occupancy does not change, so an address is held by at most one valid entry, even when the bank is full.
- R4: An insert of an absent address while all 4 slots are occupied reports cmd_ok=0 and changes no entry and no pointer. Slots whose entries were invalidated still count as occupied.
- R5: The head port shows the entry at the head slot, and head_valid=1 only when the bank is not empty and that entry is valid. A drain (cmd=2) of a non-empty bank invalidates the head entry and advances the head, so blocks leave in arrival order across pointer wrap. It reports cmd_ok=1 when the drained entry was valid.
- R6: A drain whose head entry is invalid still advances the head and reports cmd_ok=0. A drain of an empty bank changes nothing and reports cmd_ok=0.
- R7: The lookup port reports look_hit=1 only for a valid entry whose address equals look_addr. On a hit it gives that entry's dirty bit, read-version set and data in the same cycle.
- R8: A kill (cmd=3) clears the valid bit of the entry that matches cmd_addr and reports cmd_ok equal to the hit. It leaves the head and tail pointers and the arrival order of all other entries untouched.
- R9: A clean (cmd=4) clears only the dirty bit of the matching entry. The data and the valid bit remain, and cmd_ok equals the hit.
- R10: A commit (cmd=5) clears the speculative flag from the next cycle on and reports cmd_ok=1.
- R11: A wipe (cmd=6) clears every valid bit and sets both pointers to zero, which leaves the bank empty. It sets the speculative flag to 1 and loads the version from new_version. Codes 0 and 7 do nothing.
- R12: The lookup port always reflects the state before the clock edge at which a command in the same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (0 none, 1 insert, 2 drain, 3 kill, 4 clean, 5 commit, 6 wipe) |
| cmd_addr | input | 8 | Address for insert, kill and clean |
| wr_dirty | input | 1 | Dirty bit of an inserted block |
| wr_rvs | input | 4 | Read-version set of an inserted block |
| wr_data | input | 8 | Data of an inserted block |
| new_version | input | 2 | Version loaded on wipe |
| cmd_ok | output | 1 | Status of the current command |
| look_addr | input | 8 | Associative lookup key |
| look_hit | output | 1 | Lookup found a valid matching entry |
| look_dirty | output | 1 | Dirty bit of the hit entry |
| look_rvs | output | 4 | Read-version set of the hit entry |
| look_data | output | 8 | Data of the hit entry |
| head_valid | output | 1 | Head slot occupied and valid |
| head_addr | output | 8 | Address at head slot |
| head_dirty | output | 1 | Dirty bit at head slot |
| head_rvs | output | 4 | Read-version set at head slot |
| head_data | output | 8 | Data at head slot |
| bank_empty | output | 1 | No slot occupied |
| bank_full | output | 1 | All four slots occupied |
| spec_flag | output | 1 | Bank is speculative |
| version | output | 2 | Version number of the bank |

## Verification
The associative lookup and a state-changing command can act in the same cycle. The bench provokes this by pointing look_addr at the very address that the current command drains, overwrites or wipes. It then expects the lookup to return the old contents in that cycle and the new contents, or a miss, in the following cycle. The same pairing is exercised for a kill followed by reinsertion of the killed address, which has to take a fresh tail slot rather than revive the old one.

// File: rtl/vbank_pkg.sv
package vbank_pkg;

    // Field widths of one stored block; depth of a bank must be a power of two.
    localparam int VB_AW = 8;
    localparam int VB_DW = 8;
    localparam int VB_RW = 4;
    localparam int VB_VW = 2;
    localparam int VB_CW = 3;

    typedef enum logic [VB_CW-1:0] {
        OP_NOP    = 3'd0,
        OP_INSERT = 3'd1,
        OP_DRAIN  = 3'd2,
        OP_KILL   = 3'd3,
        OP_CLEAN  = 3'd4,
        OP_COMMIT = 3'd5,
        OP_WIPE   = 3'd6,
        OP_RSVD   = 3'd7
    } vb_op_e;

    typedef struct packed {
        logic             vld;
        logic [VB_AW-1:0] addr;
        logic             dirty;
        logic [VB_RW-1:0] rvs;
        logic [VB_DW-1:0] data;
    } vb_entry_t;

    // True for the commands whose status depends on an associative hit.
    function automatic logic needs_hit(input vb_op_e op);
        return (op == OP_KILL) || (op == OP_CLEAN);
    endfunction

endpackage

// File: rtl/vbank_match.sv
module vbank_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         vld,
    input  logic [DEPTH-1:0][AW-1:0] addrs,
    input  logic [AW-1:0]            key,
    output logic [DEPTH-1:0]         hits,
    output logic                     any,
    output logic [IW-1:0]            idx
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hits[g] = vld[g] && (addrs[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hits[i]) idx = IW'(i);
        end
        any = |hits;
    end

endmodule

// File: rtl/vbank_ptrs.sv
module vbank_ptrs #(
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] hd,
    output logic [PW-1:0] tl,
    output logic [PW-1:0] count,
    output logic          empty,
    output logic          full
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hd <= '0;
            tl <= '0;
        end else begin
            if (push) tl <= tl + PW'(1);
            if (pop)  hd <= hd + PW'(1);
        end
    end

    assign count = tl - hd;
    assign empty = (count == '0);
    assign full  = (count == PW'(DEPTH));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        count <= PW'(DEPTH));

    assert_no_push_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_no_pop_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/vbank_top.sv
module vbank_top
    import vbank_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int SW   = $clog2(DEPTH),
    localparam int PW   = SW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VB_CW-1:0] cmd,
    input  logic [VB_AW-1:0] cmd_addr,
    input  logic             wr_dirty,
    input  logic [VB_RW-1:0] wr_rvs,
    input  logic [VB_DW-1:0] wr_data,
    input  logic [VB_VW-1:0] new_version,
    output logic             cmd_ok,
    input  logic [VB_AW-1:0] look_addr,
    output logic             look_hit,
    output logic             look_dirty,
    output logic [VB_RW-1:0] look_rvs,
    output logic [VB_DW-1:0] look_data,
    output logic             head_valid,
    output logic [VB_AW-1:0] head_addr,
    output logic             head_dirty,
    output logic [VB_RW-1:0] head_rvs,
    output logic [VB_DW-1:0] head_data,
    output logic             bank_empty,
    output logic             bank_full,
    output logic             spec_flag,
    output logic [VB_VW-1:0] version
);

    vb_entry_t ent [DEPTH];

    logic [DEPTH-1:0]            vld_vec;
    logic [DEPTH-1:0][VB_AW-1:0] addr_vec;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i]  = ent[i].vld;
            addr_vec[i] = ent[i].addr;
        end
    end

    // Command-side associative match
    logic [DEPTH-1:0] c_hits;
    logic             c_any;
    logic [SW-1:0]    c_idx;

    vbank_match #(.DEPTH(DEPTH), .AW(VB_AW)) u_cmd_match (
        .vld   (vld_vec),
        .addrs (addr_vec),
        .key   (cmd_addr),
        .hits  (c_hits),
        .any   (c_any),
        .idx   (c_idx)
    );

    // Lookup-side associative match
    logic [DEPTH-1:0] l_hits;
    logic             l_any;
    logic [SW-1:0]    l_idx;

    vbank_match #(.DEPTH(DEPTH), .AW(VB_AW)) u_look_match (
        .vld   (vld_vec),
        .addrs (addr_vec),
        .key   (look_addr),
        .hits  (l_hits),
        .any   (l_any),
        .idx   (l_idx)
    );

    // Pointers
    vb_op_e        op;
    logic          do_push, do_pop, do_wipe;
    logic [PW-1:0] hd, tl, count;
    logic          empty, full;

    assign op      = vb_op_e'(cmd);
    assign do_push = (op == OP_INSERT) && !c_any && !full;
    assign do_pop  = (op == OP_DRAIN) && !empty;
    assign do_wipe = (op == OP_WIPE);

    vbank_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .clr   (do_wipe),
        .push  (do_push),
        .pop   (do_pop),
        .hd    (hd),
        .tl    (tl),
        .count (count),
        .empty (empty),
        .full  (full)
    );

    logic [SW-1:0] h_slot, t_slot;
    assign h_slot = hd[SW-1:0];
    assign t_slot = tl[SW-1:0];

    // Status of the command in flight
    always_comb begin
        unique case (op)
            OP_INSERT: cmd_ok = c_any || !full;
            OP_DRAIN:  cmd_ok = !empty && ent[h_slot].vld;
            default:   cmd_ok = needs_hit(op) ? c_any : 1'b1;
        endcase
    end

    // Entry storage and bank state
    logic             spec_q;
    logic [VB_VW-1:0] ver_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            spec_q <= 1'b0;
            ver_q  <= '0;
        end else begin
            unique case (op)
                OP_INSERT: begin
                    if (c_any) begin
                        ent[c_idx].dirty <= wr_dirty;
                        ent[c_idx].rvs   <= wr_rvs;
                        ent[c_idx].data  <= wr_data;
                    end else if (!full) begin
                        ent[t_slot] <= '{vld: 1'b1, addr: cmd_addr, dirty: wr_dirty,
                                         rvs: wr_rvs, data: wr_data};
                    end
                end
                OP_DRAIN: begin
                    if (!empty) ent[h_slot].vld <= 1'b0;
                end
                OP_KILL: begin
                    if (c_any) ent[c_idx].vld <= 1'b0;
                end
                OP_CLEAN: begin
                    if (c_any) ent[c_idx].dirty <= 1'b0;
                end
                OP_COMMIT: spec_q <= 1'b0;
                OP_WIPE: begin
                    for (int i = 0; i < DEPTH; i++) ent[i].vld <= 1'b0;
                    spec_q <= 1'b1;
                    ver_q  <= new_version;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    assign look_hit   = l_any;
    assign look_dirty = l_any ? ent[l_idx].dirty : 1'b0;
    assign look_rvs   = l_any ? ent[l_idx].rvs   : '0;
    assign look_data  = l_any ? ent[l_idx].data  : '0;

    assign head_valid = !empty && ent[h_slot].vld;
    assign head_addr  = ent[h_slot].addr;
    assign head_dirty = ent[h_slot].dirty;
    assign head_rvs   = ent[h_slot].rvs;
    assign head_data  = ent[h_slot].data;

    assign bank_empty = empty;
    assign bank_full  = full;
    assign spec_flag  = spec_q;
    assign version    = ver_q;

    // Assertions
    assert_unique_cmd_key_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(c_hits));

    assert_unique_look_key_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(l_hits));

    assert_insert_refused_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INSERT && full && !c_any) |=> ($stable(tl) && $stable(hd) && $stable(vld_vec)));

    assert_drain_advances_R5: assert property (@(posedge clk) disable iff (rst)
        do_pop |=> (hd == $past(hd) + PW'(1)));

    assert_kill_keeps_order_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_KILL) |=> ($stable(hd) && $stable(tl)));

    assert_commit_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_COMMIT) |=> !spec_flag);

    assert_wipe_empties_R11: assert property (@(posedge clk) disable iff (rst)
        do_wipe |=> (empty && (vld_vec == '0) && spec_flag));

endmodule

// File: tb/vbank_top_tb.sv
`timescale 1ns/100ps
module vbank_top_tb;
    import vbank_pkg::*;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd = '0;
    logic [7:0] cmd_addr = '0;
    logic       wr_dirty = 1'b0;
    logic [3:0] wr_rvs = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] new_version = '0;
    logic [7:0] look_addr = '0;
    logic       cmd_ok, look_hit, look_dirty, head_valid, head_dirty;
    logic [3:0] look_rvs, head_rvs;
    logic [7:0] look_data, head_addr, head_data;
    logic       bank_empty, bank_full, spec_flag;
    logic [1:0] version;

    always #2 clk = ~clk;

    vbank_top u_dut (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_addr(cmd_addr), .wr_dirty(wr_dirty),
        .wr_rvs(wr_rvs), .wr_data(wr_data), .new_version(new_version), .cmd_ok(cmd_ok),
        .look_addr(look_addr), .look_hit(look_hit), .look_dirty(look_dirty),
        .look_rvs(look_rvs), .look_data(look_data), .head_valid(head_valid),
        .head_addr(head_addr), .head_dirty(head_dirty), .head_rvs(head_rvs),
        .head_data(head_data), .bank_empty(bank_empty), .bank_full(bank_full),
        .spec_flag(spec_flag), .version(version)
    );

    // Scoreboard
    localparam int F_OK = 0, F_LHIT = 1, F_LDIRTY = 2, F_LRVS = 3, F_LDATA = 4,
                   F_HVALID = 5, F_HADDR = 6, F_HDIRTY = 7, F_HRVS = 8, F_HDATA = 9,
                   F_EMPTY = 10, F_FULL = 11, F_SPEC = 12, F_VER = 13;

    typedef struct {
        string tag;
        int    fld;
        int    exp;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    event  sample_ev;

    function automatic int actual(input int f);
        case (f)
            F_OK:     return int'(cmd_ok);
            F_LHIT:   return int'(look_hit);
            F_LDIRTY: return int'(look_dirty);
            F_LRVS:   return int'(look_rvs);
            F_LDATA:  return int'(look_data);
            F_HVALID: return int'(head_valid);
            F_HADDR:  return int'(head_addr);
            F_HDIRTY: return int'(head_dirty);
            F_HRVS:   return int'(head_rvs);
            F_HDATA:  return int'(head_data);
            F_EMPTY:  return int'(bank_empty);
            F_FULL:   return int'(bank_full);
            F_SPEC:   return int'(spec_flag);
            default:  return int'(version);
        endcase
    endfunction

    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                int    a;
                it = sb.pop_front();
                a  = actual(it.fld);
                checks++;
                if (a != it.exp) begin
                    fails++;
                    $display("FAIL %s field=%0d actual=%0h expected=%0h", it.tag, it.fld, a, it.exp);
                end
            end
        end
    end

    function automatic void expect_f(input string tag, input int fld, input int exp);
        item_t it;
        it.tag = tag;
        it.fld = fld;
        it.exp = exp;
        sb.push_back(it);
    endfunction

    // Reference model state
    int m_v[N], m_a[N], m_d[N], m_r[N], m_x[N];
    int m_head = 0, m_tail = 0, m_spec = 0, m_ver = 0;

    function automatic int find(input int a);
        for (int i = 0; i < N; i++) if (m_v[i] != 0 && m_a[i] == a) return i;
        return -1;
    endfunction

    task automatic step(input string tag, input int c, input int a, input int d,
                        input int r, input int x, input int vn, input int la);
        int hit, lh, cnt, hs, ok;
        @(negedge clk);
        cmd = 3'(c); cmd_addr = 8'(a); wr_dirty = d[0]; wr_rvs = 4'(r);
        wr_data = 8'(x); new_version = 2'(vn); look_addr = 8'(la);
        #0.5;
        hit = find(a);
        lh  = find(la);
        cnt = m_tail - m_head;
        hs  = m_head % N;
        case (c)
            1:       ok = (hit >= 0 || cnt < N) ? 1 : 0;
            2:       ok = (cnt > 0 && m_v[hs] != 0) ? 1 : 0;
            3, 4:    ok = (hit >= 0) ? 1 : 0;
            default: ok = 1;
        endcase
        expect_f(tag, F_OK, ok);
        expect_f(tag, F_LHIT, lh >= 0 ? 1 : 0);
        if (lh >= 0) begin
            expect_f(tag, F_LDIRTY, m_d[lh]);
            expect_f(tag, F_LRVS, m_r[lh]);
            expect_f(tag, F_LDATA, m_x[lh]);
        end
        expect_f(tag, F_HVALID, (cnt > 0 && m_v[hs] != 0) ? 1 : 0);
        if (cnt > 0 && m_v[hs] != 0) begin
            expect_f(tag, F_HADDR, m_a[hs]);
            expect_f(tag, F_HDIRTY, m_d[hs]);
            expect_f(tag, F_HRVS, m_r[hs]);
            expect_f(tag, F_HDATA, m_x[hs]);
        end
        expect_f(tag, F_EMPTY, cnt == 0 ? 1 : 0);
        expect_f(tag, F_FULL, cnt == N ? 1 : 0);
        expect_f(tag, F_SPEC, m_spec);
        expect_f(tag, F_VER, m_ver);
        ->sample_ev;
        #0.5;
        // model update for the coming edge
        case (c)
            1: begin
                if (hit >= 0) begin
                    m_d[hit] = d; m_r[hit] = r; m_x[hit] = x;
                end else if (cnt < N) begin
                    int ts;
                    ts = m_tail % N;
                    m_v[ts] = 1; m_a[ts] = a; m_d[ts] = d; m_r[ts] = r; m_x[ts] = x;
                    m_tail++;
                end
            end
            2: if (cnt > 0) begin m_v[hs] = 0; m_head++; end
            3: if (hit >= 0) m_v[hit] = 0;
            4: if (hit >= 0) m_d[hit] = 0;
            5: m_spec = 0;
            6: begin
                for (int i = 0; i < N; i++) m_v[i] = 0;
                m_head = 0; m_tail = 0; m_spec = 1; m_ver = vn;
            end
            default: ;
        endcase
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_a[i] = 0; m_d[i] = 0; m_r[i] = 0; m_x[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        step("R1", 0, 8'h00, 0, 0, 0, 0, 8'h10);
        step("R2", 1, 8'h10, 1, 3, 8'hA1, 0, 8'h10);
        step("R2", 0, 0, 0, 0, 0, 0, 8'h10);
        step("R2", 1, 8'h20, 1, 5, 8'hB2, 0, 8'h20);
        step("R2", 1, 8'h30, 0, 6, 8'hC3, 0, 8'h30);
        step("R12", 1, 8'h20, 0, 9, 8'h5E, 0, 8'h20);
        step("R3", 0, 0, 0, 0, 0, 0, 8'h20);
        step("R2", 1, 8'h40, 1, 1, 8'hD4, 0, 8'h40);
        step("R4", 1, 8'h50, 1, 2, 8'hE5, 0, 8'h50);
        step("R4", 0, 0, 0, 0, 0, 0, 8'h50);
        step("R3", 1, 8'h30, 1, 15, 8'h77, 0, 8'h30);
        step("R3", 0, 0, 0, 0, 0, 0, 8'h30);
        step("R9", 4, 8'h10, 0, 0, 0, 0, 8'h10);
        step("R9", 0, 0, 0, 0, 0, 0, 8'h10);
        step("R9", 4, 8'h99, 0, 0, 0, 0, 8'h99);
        step("R8", 3, 8'h20, 0, 0, 0, 0, 8'h20);
        step("R8", 0, 0, 0, 0, 0, 0, 8'h20);
        step("R7", 3, 8'h20, 0, 0, 0, 0, 8'h30);
        step("R4", 1, 8'h60, 0, 0, 8'h66, 0, 8'h60);
        step("R12", 2, 0, 0, 0, 0, 0, 8'h10);
        step("R5", 0, 0, 0, 0, 0, 0, 8'h10);
        step("R6", 2, 0, 0, 0, 0, 0, 8'h20);
        step("R2", 1, 8'h70, 1, 4, 8'h71, 0, 8'h70);
        step("R8", 1, 8'h20, 1, 8, 8'h22, 0, 8'h20);
        step("R8", 0, 0, 0, 0, 0, 0, 8'h20);
        for (int k = 0; k < 4; k++) step("R5", 2, 0, 0, 0, 0, 0, 8'h30);
        step("R6", 2, 0, 0, 0, 0, 0, 8'h30);
        // wrap the pointers several times while keeping arrival order
        for (int k = 0; k < 12; k++) begin
            step("R2", 1, 8'h80 + k, k & 1, k & 15, 8'h10 + k, 0, 8'h80 + k);
            step("R2", 1, 8'hC0 + k, 1, 3, 8'h90 + k, 0, 8'hC0 + k);
            step("R5", 2, 0, 0, 0, 0, 0, 8'hC0 + k);
            step("R5", 2, 0, 0, 0, 0, 0, 8'h80 + k);
        end
        step("R11", 1, 8'h11, 1, 1, 8'h01, 0, 8'h11);
        step("R11", 1, 8'h12, 0, 2, 8'h02, 0, 8'h12);
        step("R12", 6, 0, 0, 0, 0, 2, 8'h11);
        step("R11", 0, 0, 0, 0, 0, 0, 8'h11);
        step("R11", 7, 8'h12, 0, 0, 0, 3, 8'h12);
        step("R10", 5, 0, 0, 0, 0, 0, 8'h00);
        step("R10", 0, 0, 0, 0, 0, 0, 8'h00);
        step("R11", 6, 0, 0, 0, 0, 1, 8'h00);
        step("R11", 0, 0, 0, 0, 0, 0, 8'h00);
        @(negedge clk);
        cmd = '0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_head = 0; m_tail = 0; m_spec = 0; m_ver = 0;
        step("R1", 0, 0, 0, 0, 0, 0, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule